// File: doc/BRIEF.md
# Configurable-Frame UART Transmitter

This block turns bytes into an asynchronous serial stream. It takes each byte from a first-in first-out buffer through a simple pop interface. It then drives the byte onto a single output line as a frame: a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. The line rests high between frames.

A 7-bit line-control input sets the frame shape. It selects a character length of 5 to 8 bits, whether a parity bit is sent, which of four parity rules applies, and the number of stop bits. A 16-bit divisor sets the bit time. The block takes a snapshot of the shape and the divisor on the cycle it pops a byte, so software can change them while a frame is going out without harm. A break bit in the same control input pulls the line low at once and holds it there for as long as it stays set. A shift-register-empty flag tells the surrounding logic when the last frame has fully left the block.

The controller has five states. In IDLE, a non-empty buffer causes a pop and the move IDLE→START. START always moves to DATA after one bit time. DATA stays put until the last selected data bit is done, then moves DATA→PARITY if parity is on, or DATA→STOP if it is off. PARITY moves to STOP after one bit time. STOP returns STOP→IDLE after one or two bit times.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `tsr_empty` is 1, and `fifo_pop` stays 0 for as long as `fifo_empty` is 1.
- R2: When the block is idle and `fifo_empty` is 0, `fifo_pop` is 1 in that same cycle. The byte on `fifo_data` is taken at the next rising edge, and `tsr_empty` is 0 from the following cycle.
- R3: A frame is sent in this order: a start bit of 0, then the data bits least significant first, then the optional parity bit, then the stop bits of 1.
- R4: `line_ctl[1:0]` sets the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are not sent.
- R5: `line_ctl[2]` set to 0 gives one stop bit; set to 1 it gives two stop bits.
- R6: `line_ctl[3]` set to 1 adds a parity bit after the data bits; set to 0 the frame has no parity bit.
- R7: `line_ctl[5:4]` picks the parity rule: 00 is odd, 01 is even, 10 forces the bit to 1, 11 forces it to 0. Odd and even parity count only the selected data bits.
- R8: Every bit lasts 16 × `divisor` clock cycles. A `divisor` of 0 behaves as 1.
- R9: While `line_ctl[6]` is 1, `txd` is 0, whether the block is idle or in mid-frame. The frame timing carries on underneath, and the frame resumes normally once the bit is cleared.
- R10: The block samples `line_ctl[5:0]` and `divisor` on the edge that pops the byte. Changes to them during the frame do not affect that frame.
- R11: `tsr_empty` rises in the first cycle after the last stop bit's full period. It stays 1 until the next byte is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_ctl | input | 7 | Frame shape: [1:0] length, [2] two stops, [3] parity on, [5:4] parity rule, [6] break |
| divisor | input | 16 | Bit time in units of 16 clock cycles |
| fifo_empty | input | 1 | Buffer has no byte |
| fifo_data | input | 8 | Byte at the head of the buffer |
| fifo_pop | output | 1 | Take the head byte at this edge |
| txd | output | 1 | Serial output line |
| tsr_empty | output | 1 | No frame in flight |

## Verification
The hardest cases to reach are the ones that change inputs while a frame is in flight. One is a change of frame shape and divisor in the middle of a frame, which must not disturb that frame. The other is a break that starts and ends partway through a frame. To reach them, the bench pops a byte and then rewrites `line_ctl` and `divisor` on the next falling edge. It then samples every bit at its midpoint against the shape that was sampled at the pop, clearing the break between two bit midpoints. The main sweep covers every combination of length, parity rule and stop count with three data patterns. The patterns are chosen so that the bits above the selected length would change the parity if they were counted.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] par_mode;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } frame_cfg_t;

    localparam logic [1:0] PAR_ODD   = 2'b00;
    localparam logic [1:0] PAR_EVEN  = 2'b01;
    localparam logic [1:0] PAR_MARK  = 2'b10;
    localparam logic [1:0] PAR_SPACE = 2'b11;

    // R7: parity is computed over the selected character length only.
    function automatic logic calc_parity(input logic [7:0] d, input frame_cfg_t c);
        logic [7:0] masked;
        logic       x;
        masked = d & (8'hFF >> (2'd3 - c.wlen));
        x = ^masked;
        unique case (c.par_mode)
            PAR_ODD:   calc_parity = ~x;
            PAR_EVEN:  calc_parity = x;
            PAR_MARK:  calc_parity = 1'b1;
            PAR_SPACE: calc_parity = 1'b0;
            default:   calc_parity = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_q,
    output logic             bit_done
);
    localparam int CNT_W = DIV_W + $clog2(OVS);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic [DIV_W-1:0] eff_div;

    // R8: a zero divisor behaves as one.
    always_comb begin
        eff_div  = (div_q == '0) ? DIV_W'(1) : div_q;
        last     = CNT_W'(eff_div) * CNT_W'(OVS) - CNT_W'(1);
        bit_done = run && (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || bit_done)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_empty,
    input  logic [7:0]       fifo_data,
    input  frame_cfg_t       cfg_in,
    input  logic [DIV_W-1:0] div_in,
    input  logic             bit_done,
    output logic             fifo_pop,
    output logic             line_bit,
    output logic             run,
    output logic             tsr_empty,
    output logic [DIV_W-1:0] div_q
);
    tx_state_e  state, state_n;
    logic [7:0] shreg;
    logic [2:0] bit_cnt;
    logic [2:0] last_data;
    frame_cfg_t cfg_q;
    logic       par_q;
    logic       load;

    assign load      = (state == ST_IDLE) && !fifo_empty;
    assign last_data = 3'(cfg_q.wlen) + 3'd4;   // R4

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (!fifo_empty) state_n = ST_START;
            ST_START:  if (bit_done) state_n = ST_DATA;
            ST_DATA:   if (bit_done && bit_cnt == last_data)
                           state_n = cfg_q.par_en ? ST_PARITY : ST_STOP;  // R6
            ST_PARITY: if (bit_done) state_n = ST_STOP;
            ST_STOP:   if (bit_done && (bit_cnt[0] || !cfg_q.two_stop))   // R5
                           state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fifo_pop = load;
        run      = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:   line_bit = 1'b1;
            ST_START:  line_bit = 1'b0;
            ST_DATA:   line_bit = shreg[0];
            ST_PARITY: line_bit = par_q;
            ST_STOP:   line_bit = 1'b1;
            default:   line_bit = 1'b1;
        endcase
    end

    // Datapath: R10 snapshot at the popping edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            cfg_q     <= '0;
            div_q     <= '0;
            par_q     <= 1'b0;
            bit_cnt   <= '0;
            tsr_empty <= 1'b1;
        end else begin
            if (load) begin
                shreg <= fifo_data;
                cfg_q <= cfg_in;
                div_q <= div_in;
                par_q <= calc_parity(fifo_data, cfg_in);
            end else if (state == ST_DATA && bit_done) begin
                shreg <= shreg >> 1;
            end
            if (load)
                bit_cnt <= '0;
            else if (bit_done)
                bit_cnt <= (state_n != state) ? 3'd0 : bit_cnt + 3'd1;
            if (load)
                tsr_empty <= 1'b0;
            else if (state == ST_STOP && state_n == ST_IDLE)
                tsr_empty <= 1'b1;                       // R11
        end
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [6:0]       line_ctl,
    input  logic [DIV_W-1:0] divisor,
    input  logic             fifo_empty,
    input  logic [7:0]       fifo_data,
    output logic             fifo_pop,
    output logic             txd,
    output logic             tsr_empty
);
    frame_cfg_t       cfg_in;
    logic             bit_done;
    logic             run;
    logic             line_bit;
    logic [DIV_W-1:0] div_q;

    always_comb begin
        cfg_in.wlen     = line_ctl[1:0];
        cfg_in.two_stop = line_ctl[2];
        cfg_in.par_en   = line_ctl[3];
        cfg_in.par_mode = line_ctl[5:4];
    end

    uart_tx_bitclk #(.DIV_W(DIV_W), .OVS(OVS)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_q    (div_q),
        .bit_done (bit_done)
    );

    uart_tx_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_empty(fifo_empty),
        .fifo_data (fifo_data),
        .cfg_in    (cfg_in),
        .div_in    (divisor),
        .bit_done  (bit_done),
        .fifo_pop  (fifo_pop),
        .line_bit  (line_bit),
        .run       (run),
        .tsr_empty (tsr_empty),
        .div_q     (div_q)
    );

    // R9: the break bit overrides the line without stopping the frame
    assign txd = line_ctl[6] ? 1'b0 : line_bit;
endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] line_ctl,
    input logic       fifo_empty,
    input logic       fifo_pop,
    input logic       txd,
    input logic       tsr_empty
);
    AST_POP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (tsr_empty && !fifo_empty)); // R2
    AST_POP_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !tsr_empty); // R2
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tsr_empty && !line_ctl[6]) |-> txd); // R1
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tsr_empty) && !line_ctl[6]) |-> !txd); // R3
    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tsr_empty && fifo_empty) |=> tsr_empty); // R11
    AST_BREAK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctl[6] |-> !txd); // R9
endmodule

bind uart_frame_tx uart_tx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_ctl  (line_ctl),
    .fifo_empty(fifo_empty),
    .fifo_pop  (fifo_pop),
    .txd       (txd),
    .tsr_empty (tsr_empty)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  line_ctl;
    logic [15:0] divisor;
    logic        fifo_empty;
    logic [7:0]  fifo_data;
    logic        fifo_pop, txd, tsr_empty;
    int          checks = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    uart_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .line_ctl(line_ctl), .divisor(divisor),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .txd(txd), .tsr_empty(tsr_empty)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Pops one byte, then applies mid-frame control/divisor values and an optional break
    task automatic send(input logic [7:0] d, input logic [6:0] lc, input logic [15:0] dv,
                        input logic [6:0] lc_mid, input logic [15:0] dv_mid,
                        input int brk_bits, input string tag);
        logic [15:0] b;
        string       lbl [16];
        int wl, n, p, ones;
        b = '0; n = 0; ones = 0;
        wl = 5 + int'(lc[1:0]);
        p  = 16 * ((dv == 0) ? 1 : int'(dv));
        b[n] = 1'b0; lbl[n] = "R3 start"; n++;
        for (int i = 0; i < wl; i++) begin
            b[n] = d[i]; lbl[n] = "R4 data"; n++;
            ones += int'(d[i]);
        end
        if (lc[3]) begin
            case (lc[5:4])
                2'b00: b[n] = (ones % 2 == 0);
                2'b01: b[n] = (ones % 2 == 1);
                2'b10: b[n] = 1'b1;
                default: b[n] = 1'b0;
            endcase
            lbl[n] = "R7 R6 parity"; n++;
        end
        b[n] = 1'b1; lbl[n] = "R5 stop"; n++;
        if (lc[2]) begin b[n] = 1'b1; lbl[n] = "R5 stop2"; n++; end

        @(negedge clk);
        line_ctl = lc; divisor = dv; fifo_data = d; fifo_empty = 1'b0;
        #1 chk($sformatf("R2 pop %s", tag), int'(fifo_pop), 1);
        @(posedge clk);
        @(negedge clk);
        fifo_empty = 1'b1; fifo_data = ~d;
        line_ctl = lc_mid | ((brk_bits > 0) ? 7'h40 : 7'h00);
        divisor = dv_mid;
        chk($sformatf("R2 busy %s", tag), int'(tsr_empty), 0);
        for (int i = 0; i < n; i++) begin
            if (brk_bits > 0 && i == brk_bits) line_ctl[6] = 1'b0;
            repeat ((i == 0) ? p / 2 : p) @(posedge clk);
            @(negedge clk);
            if (i < brk_bits)
                chk($sformatf("R9 break bit%0d %s", i, tag), int'(txd), 0);
            else
                chk($sformatf("%s bit%0d %s", lbl[i], i, tag), int'(txd), int'(b[i]));
        end
        repeat (p / 2 - 1) @(posedge clk);
        @(negedge clk);
        chk($sformatf("R8 R11 last cycle busy %s", tag), int'(tsr_empty), 0);
        @(posedge clk);
        @(negedge clk);
        chk($sformatf("R11 empty after frame %s", tag), int'(tsr_empty), 1);
        chk($sformatf("R1 idle line %s", tag), int'(txd), 1);
    endtask

    initial begin
        line_ctl = 7'h03; divisor = 16'd1; fifo_empty = 1'b1; fifo_data = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 txd in reset", int'(txd), 1);
        chk("R1 tsr_empty in reset", int'(tsr_empty), 1);
        rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            chk("R1 no pop while empty", int'(fifo_pop), 0);
            chk("R1 idle txd", int'(txd), 1);
            chk("R11 idle tsr_empty", int'(tsr_empty), 1);
        end

        // Sweep over lengths, parity rules (4 = off) and stop counts
        for (int wl = 0; wl < 4; wl++)
            for (int pm = 0; pm < 5; pm++)
                for (int st = 0; st < 2; st++)
                    for (int dp = 0; dp < 3; dp++) begin
                        logic [6:0] lc;
                        logic [7:0] d;
                        d  = (dp == 0) ? 8'hA5 : (dp == 1) ? 8'h1E : 8'hE3;
                        lc = {1'b0, (pm < 4) ? 2'(pm) : 2'b00, (pm < 4), 1'(st), 2'(wl)};
                        send(d, lc, 16'd1, lc, 16'd1, 0,
                             $sformatf("R4 R5 R6 R7 lc=%02h d=%02h", lc, d));
                    end

        // R8: divisor of zero, and longer bit periods
        send(8'h96, 7'h03, 16'd0, 7'h03, 16'd0, 0, "R8 div0");
        send(8'h4D, 7'h03, 16'd3, 7'h03, 16'd3, 0, "R8 div3");
        send(8'hC2, 7'h1F, 16'd2, 7'h1F, 16'd2, 0, "R8 div2 even 2stop");

        // R10: shape and divisor rewritten just after the pop
        send(8'h6B, 7'h03, 16'd2, 7'h3C, 16'd1, 0, "R10 mid change");
        send(8'h31, 7'h2C, 16'd1, 7'h07, 16'd4, 0, "R10 mid change 2");

        // R9: break over the first three bits of a frame, then released
        send(8'hFF, 7'h03, 16'd1, 7'h03, 16'd1, 3, "R9 mid-frame break");

        // R9: break while idle
        @(negedge clk);
        line_ctl = 7'h43;
        #1 chk("R9 idle break txd", int'(txd), 0);
        chk("R9 idle break tsr_empty", int'(tsr_empty), 1);
        @(negedge clk);
        line_ctl = 7'h03;
        #1 chk("R9 break released", int'(txd), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule